// File: doc/BRIEF.md
# Addend-Trimmed Time-of-Day Counter

This block keeps a free-running 64-bit time-of-day count whose rate is set by a fractional addend rather than by the core clock alone. On every core clock a 32-bit addend is summed into a 32-bit accumulator, modulo 2^32. The time count advances by one only in a cycle where that sum carries out of the accumulator. Software trims the clock rate by nudging the addend around its nominal value. One count stands for 32 ns, so software converts the count to nanoseconds with a left shift by five.

Software reaches the block through a small 32-bit register bus with eight word slots. The 64-bit time is split into two words. A write to the low word is staged, and the later high-word write commits both halves in one cycle. A read of the low word captures the high word in a shadow, so the high read that follows belongs to the same instant. A 64-bit target register drives a three-state machine. **ARMED** goes to **PENDING** when the time is at or past the target. **PENDING** goes to **SPENT** when software writes 1 to the event bit. **SPENT** goes back to **ARMED** on any write to either target word. A soft-reset bit in the control word forces the state to ARMED, and it also clears the count while the bit is held. The interrupt is the target event gated by a mask bit.

Top module: `trim_clock_top`

## Requirements
- R1: The addend (word 2) reads 0xA0000000 after hardware reset and after a soft reset. A write replaces it from the next cycle.
- R2: Each cycle the accumulator (word 3) becomes accumulator + addend modulo 2^32. The time count rises by exactly one in each cycle where that sum carries out, and stays unchanged in every other cycle. A write to word 3 loads the accumulator, and the count does not advance in that cycle.
- R3: A write to the time low word (word 4) changes nothing visible. The next write to the time high word (word 5) loads the full 64-bit count, with the staged low value, in a single cycle.
- R4: A read of word 4 returns the live low 32 bits and captures the live high 32 bits. A read of word 5 returns the captured value, even if the count has carried into its high half since then.
- R5: Control word 0, bit 0 is a soft reset. While it is set, the count, the accumulator and the event are held at zero, the addend at nominal and the target at all ones. Control bit 1 is the interrupt mask. Both bits read back.
- R6: The target words 6 (low) and 7 (high) reset to all ones. Event word 1, bit 1 sets once the count, compared as a 64-bit unsigned value, is greater than or equal to the target.
- R7: Writing 1 to event bit 1 clears a pending event, and writing 0 leaves it set. After a clear, the event stays clear even while the count remains at or above the target.
- R8: A write to either target word re-arms the compare after a clear. While an event is pending, target writes leave the event set.
- R9: The irq output is high exactly when event bit 1 is set and control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq | output | 1 | Masked target-reached interrupt |

## Verification
The bench runs several addends, including zero, one and the all-ones value. It compares the count and the accumulator against a product computed from the number of elapsed cycles. A design that ticked on every cycle, or dropped the carry, would miss these values. One bench check reads the low word just before the low half wraps, then reads the high word several cycles later. A design without the shadow would return the already incremented high half. Another check writes only the low word. A design that applied it at once would read back the new low value. A target is placed in the next high word while the live low word is already larger. A compare done on the low half only would fire early. The bench also checks that a cleared event does not set again while the count stays past the target, and that only a target write re-arms it.

// File: rtl/trim_clock_pkg.sv
package trim_clock_pkg;

    // Register word indices on the control bus
    typedef enum logic [2:0] {
        RI_CTRL    = 3'd0,
        RI_EVENT   = 3'd1,
        RI_ADDEND  = 3'd2,
        RI_ACCUM   = 3'd3,
        RI_TIME_LO = 3'd4,
        RI_TIME_HI = 3'd5,
        RI_TGT_LO  = 3'd6,
        RI_TGT_HI  = 3'd7
    } reg_idx_e;

    // Target compare states
    typedef enum logic [1:0] {
        TGT_ARMED   = 2'd0,
        TGT_PENDING = 2'd1,
        TGT_SPENT   = 2'd2
    } tgt_state_e;

    localparam int CTRL_SRST_BIT = 0;
    localparam int CTRL_MASK_BIT = 1;
    localparam int CTRL_W        = 2;
    localparam int EVT_TGT_BIT   = 1;

endpackage

// File: rtl/trim_rate_accum.sv
module trim_rate_accum #(
    parameter int          W       = 32,
    parameter logic [W-1:0] NOMINAL = 32'hA000_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         addend_we,
    input  logic         acc_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] addend_q,
    output logic [W-1:0] acc_q,
    output logic         tick
);

    logic [W:0] sum;

    assign sum  = {1'b0, acc_q} + {1'b0, addend_q};
    assign tick = sum[W] & ~srst & ~acc_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addend_q <= NOMINAL;
            acc_q    <= '0;
        end else if (srst) begin
            addend_q <= NOMINAL;
            acc_q    <= '0;
        end else begin
            if (addend_we) begin
                addend_q <= wdata;
            end
            acc_q <= acc_we ? wdata : sum[W-1:0];
        end
    end

    // R1
    nominal_after_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srst) |-> (addend_q == NOMINAL && acc_q == '0));

endmodule

// File: rtl/trim_time_core.sv
module trim_time_core #(
    parameter int W  = 32,
    parameter int TW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          tick,
    input  logic          lo_we,
    input  logic          hi_we,
    input  logic          lo_rd,
    input  logic [W-1:0]  wdata,
    output logic [TW-1:0] time_q,
    output logic [W-1:0]  shadow_q
);

    logic [W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q   <= '0;
            stage_q  <= '0;
            shadow_q <= '0;
        end else if (srst) begin
            time_q   <= '0;
            stage_q  <= '0;
            shadow_q <= '0;
        end else begin
            if (lo_we) begin
                stage_q <= wdata;
            end
            if (hi_we) begin
                time_q <= {wdata, stage_q};
            end else if (tick) begin
                time_q <= time_q + 1'b1;
            end
            if (lo_rd) begin
                shadow_q <= time_q[TW-1:W];
            end
        end
    end

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(hi_we) && !$past(srst) && (time_q != $past(time_q)))
            |-> ($past(tick) && time_q == $past(time_q) + 1'b1));

    // R3
    hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hi_we) && !$past(srst)) |-> (time_q == {$past(wdata), $past(stage_q)}));

    // R4
    shadow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lo_rd) && !$past(srst)) |-> (shadow_q == $past(time_q[TW-1:W])));

endmodule

// File: rtl/trim_target_fsm.sv
module trim_target_fsm
    import trim_clock_pkg::*;
#(
    parameter int W  = 32,
    parameter int TW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic [TW-1:0] time_in,
    input  logic          tlo_we,
    input  logic          thi_we,
    input  logic [W-1:0]  wdata,
    input  logic          evt_clr,
    output logic [TW-1:0] target_q,
    output logic          evt
);

    tgt_state_e state_q, state_d;
    logic       reached;

    assign reached = (time_in >= target_q);

    // Target words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '1;
        end else if (srst) begin
            target_q <= '1;
        end else begin
            if (tlo_we) begin
                target_q[W-1:0] <= wdata;
            end
            if (thi_we) begin
                target_q[TW-1:W] <= wdata;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TGT_ARMED;
        end else if (srst) begin
            state_q <= TGT_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TGT_ARMED:   if (reached)          state_d = TGT_PENDING;
            TGT_PENDING: if (evt_clr)          state_d = TGT_SPENT;
            TGT_SPENT:   if (tlo_we || thi_we) state_d = TGT_ARMED;
            default:                           state_d = TGT_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        evt = (state_q == TGT_PENDING);
    end

    // R6
    evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |-> $past(time_in >= target_q));

    // R7
    evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_clr) && $past(evt)) |-> !evt);

endmodule

// File: rtl/trim_clock_top.sv
module trim_clock_top
    import trim_clock_pkg::*;
#(
    parameter int          BUS_W   = 32,
    parameter logic [BUS_W-1:0] NOMINAL = 32'hA000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq
);

    localparam int TW = 2 * BUS_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic              srst;
    logic [7:0]        wr_hit;
    logic              lo_rd;
    logic [BUS_W-1:0]  addend_q, acc_q, shadow_q;
    logic              tick;
    logic [TW-1:0]     time_q, target_q;
    logic              evt;
    logic              evt_clr;
    logic [BUS_W-1:0]  evt_word, ctrl_word;

    // One write strobe per register word
    for (genvar g = 0; g < 8; g++) begin : g_wdec
        assign wr_hit[g] = bus_sel & bus_wr & (bus_addr == 3'(g));
    end

    assign lo_rd   = bus_sel & ~bus_wr & (bus_addr == RI_TIME_LO);
    assign srst    = ctrl_q[CTRL_SRST_BIT];
    assign evt_clr = wr_hit[RI_EVENT] & bus_wdata[EVT_TGT_BIT];
    assign irq     = evt & ctrl_q[CTRL_MASK_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_hit[RI_CTRL]) begin
            ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    trim_rate_accum #(.W(BUS_W), .NOMINAL(NOMINAL)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .addend_we (wr_hit[RI_ADDEND]),
        .acc_we    (wr_hit[RI_ACCUM]),
        .wdata     (bus_wdata),
        .addend_q  (addend_q),
        .acc_q     (acc_q),
        .tick      (tick)
    );

    trim_time_core #(.W(BUS_W), .TW(TW)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .tick     (tick),
        .lo_we    (wr_hit[RI_TIME_LO]),
        .hi_we    (wr_hit[RI_TIME_HI]),
        .lo_rd    (lo_rd),
        .wdata    (bus_wdata),
        .time_q   (time_q),
        .shadow_q (shadow_q)
    );

    trim_target_fsm #(.W(BUS_W), .TW(TW)) u_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .time_in  (time_q),
        .tlo_we   (wr_hit[RI_TGT_LO]),
        .thi_we   (wr_hit[RI_TGT_HI]),
        .wdata    (bus_wdata),
        .evt_clr  (evt_clr),
        .target_q (target_q),
        .evt      (evt)
    );

    always_comb begin
        evt_word              = '0;
        evt_word[EVT_TGT_BIT] = evt;
        ctrl_word             = '0;
        ctrl_word[CTRL_W-1:0] = ctrl_q;
    end

    always_comb begin
        unique case (reg_idx_e'(bus_addr))
            RI_CTRL:    bus_rdata = ctrl_word;
            RI_EVENT:   bus_rdata = evt_word;
            RI_ADDEND:  bus_rdata = addend_q;
            RI_ACCUM:   bus_rdata = acc_q;
            RI_TIME_LO: bus_rdata = time_q[BUS_W-1:0];
            RI_TIME_HI: bus_rdata = shadow_q;
            RI_TGT_LO:  bus_rdata = target_q[BUS_W-1:0];
            RI_TGT_HI:  bus_rdata = target_q[TW-1:BUS_W];
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/trim_clock_top_bench.sv
module trim_clock_top_bench;

    localparam logic [2:0] A_CTRL = 3'd0, A_EVT = 3'd1, A_ADD = 3'd2, A_ACC = 3'd3,
                           A_TLO = 3'd4, A_THI = 3'd5, A_GLO = 3'd6, A_GHI = 3'd7;

    // {addend, extra wait cycles}
    localparam logic [63:0] VEC [5] = '{
        64'hA0000000_00000007,
        64'h80000000_00000004,
        64'hFFFFFFFF_00000009,
        64'h00000001_00000003,
        64'h00000000_00000005
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int unsigned cyc = 0;
    int unsigned last_wr = 0;
    int unsigned last_rd = 0;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trim_clock_top u_trim_clock_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [63:0] ticks_of(int unsigned n, logic [31:0] a);
        logic [63:0] p;
        p = 64'(n) * 64'(a);
        return p >> 32;
    endfunction

    function automatic logic [31:0] acc_of(int unsigned n, logic [31:0] a);
        logic [63:0] p;
        p = 64'(n) * 64'(a);
        return p[31:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        last_wr = cyc;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        last_rd = cyc;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] t0, t;
        int unsigned ea, n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(A_CTRL, v); chk("R5 ctrl reset", v, 32'h0);
        rd(A_EVT, v);  chk("R6 event reset", v, 32'h0);
        rd(A_ADD, v);  chk("R1 addend reset", v, 32'hA0000000);
        rd(A_GLO, v);  chk("R6 target lo reset", v, 32'hFFFFFFFF);
        rd(A_GHI, v);  chk("R6 target hi reset", v, 32'hFFFFFFFF);
        chk("R9 irq reset", 32'(irq), 32'h0);

        // Vector table: rate for several addends
        for (int i = 0; i < 5; i++) begin
            logic [31:0] a;
            int unsigned w;
            a = VEC[i][63:32];
            w = VEC[i][31:0];
            wr(A_ADD, 32'h0);
            wr(A_ACC, 32'h0);
            wr(A_TLO, 32'h0);
            wr(A_THI, 32'h0);
            wr(A_ADD, a);
            ea = last_wr;
            repeat (w) @(negedge clk);
            wr(A_ADD, 32'h0);
            n = last_wr - ea;
            t = ticks_of(n, a);
            rd(A_TLO, v); chk("R2 time lo", v, t[31:0]);
            rd(A_THI, v); chk("R2 time hi", v, t[63:32]);
            rd(A_ACC, v); chk("R2 accumulator", v, acc_of(n, a));
        end

        // R3 staged write
        wr(A_TLO, 32'h13579BDF);
        wr(A_THI, 32'h2468ACE0);
        rd(A_TLO, v); chk("R3 commit lo", v, 32'h13579BDF);
        rd(A_THI, v); chk("R3 commit hi", v, 32'h2468ACE0);
        wr(A_TLO, 32'h11111111);
        rd(A_TLO, v); chk("R3 low alone no effect", v, 32'h13579BDF);
        rd(A_THI, v); chk("R3 high unchanged", v, 32'h2468ACE0);
        wr(A_THI, 32'h22222222);
        rd(A_TLO, v); chk("R3 second commit lo", v, 32'h11111111);
        rd(A_THI, v); chk("R3 second commit hi", v, 32'h22222222);

        // R4 shadow across low-word wrap
        wr(A_ACC, 32'h0);
        t0 = 64'h00000007_FFFFFFFC;
        wr(A_TLO, t0[31:0]);
        wr(A_THI, t0[63:32]);
        wr(A_ADD, 32'hFFFFFFFF);
        ea = last_wr;
        rd(A_TLO, v);
        t = t0 + ticks_of(last_rd - ea, 32'hFFFFFFFF);
        chk("R4 live low", v, t[31:0]);
        repeat (6) @(negedge clk);
        rd(A_THI, v); chk("R4 shadow high", v, t[63:32]);
        wr(A_ADD, 32'h0);
        t = t0 + ticks_of(last_wr - ea, 32'hFFFFFFFF);
        rd(A_TLO, v); chk("R4 frozen low", v, t[31:0]);
        rd(A_THI, v); chk("R4 frozen high", v, t[63:32]);

        // Target event
        wr(A_ACC, 32'h0);
        wr(A_TLO, 32'h0);
        wr(A_THI, 32'h0);
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, v); chk("R5 ctrl readback", v, 32'h2);
        wr(A_GLO, 32'd20);
        wr(A_GHI, 32'h0);
        rd(A_EVT, v); chk("R6 below target", v, 32'h0);
        wr(A_ADD, 32'hFFFFFFFF);
        repeat (30) @(negedge clk);
        wr(A_ADD, 32'h0);
        rd(A_EVT, v); chk("R6 target reached", v, 32'h2);
        chk("R9 irq masked on", 32'(irq), 32'h1);
        wr(A_CTRL, 32'h0);
        chk("R9 irq masked off", 32'(irq), 32'h0);
        rd(A_EVT, v); chk("R9 event kept when masked", v, 32'h2);
        wr(A_CTRL, 32'h2);
        chk("R9 irq re-enabled", 32'(irq), 32'h1);
        wr(A_EVT, 32'h0);
        rd(A_EVT, v); chk("R7 write zero keeps", v, 32'h2);
        wr(A_EVT, 32'h2);
        rd(A_EVT, v); chk("R7 write one clears", v, 32'h0);
        chk("R9 irq after clear", 32'(irq), 32'h0);
        repeat (5) @(negedge clk);
        rd(A_EVT, v); chk("R7 sets once", v, 32'h0);
        wr(A_GHI, 32'h0);
        rd(A_EVT, v); chk("R8 rearm fires", v, 32'h2);
        wr(A_GHI, 32'hFFFFFFFF);
        rd(A_EVT, v); chk("R8 pending kept", v, 32'h2);
        wr(A_EVT, 32'h2);
        wr(A_GHI, 32'hFFFFFFFF);
        rd(A_EVT, v); chk("R8 rearm far target", v, 32'h0);

        // R6 full-width compare
        wr(A_TLO, 32'hFFFFFFF0);
        wr(A_THI, 32'h0);
        wr(A_GLO, 32'h0);
        wr(A_GHI, 32'h1);
        rd(A_EVT, v); chk("R6 high word compare", v, 32'h0);
        wr(A_ADD, 32'hFFFFFFFF);
        repeat (8) @(negedge clk);
        wr(A_ADD, 32'h0);
        rd(A_EVT, v); chk("R6 not yet across", v, 32'h0);
        wr(A_ADD, 32'hFFFFFFFF);
        repeat (25) @(negedge clk);
        wr(A_ADD, 32'h0);
        rd(A_EVT, v); chk("R6 across word boundary", v, 32'h2);

        // R5 soft reset
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_TLO, v); chk("R5 time held", v, 32'h0);
        rd(A_ACC, v); chk("R5 accum held", v, 32'h0);
        rd(A_ADD, v); chk("R1 addend nominal on soft reset", v, 32'hA0000000);
        rd(A_EVT, v); chk("R5 event cleared", v, 32'h0);
        chk("R9 irq cleared", 32'(irq), 32'h0);
        wr(A_CTRL, 32'h0);
        ea = last_wr;
        rd(A_ACC, v); chk("R2 accum after release", v, acc_of(last_rd - ea, 32'hA0000000));
        rd(A_TLO, v);
        t = ticks_of(last_rd - ea, 32'hA0000000);
        chk("R2 time after release", v, t[31:0]);
        rd(A_GLO, v); chk("R5 target restored", v, 32'hFFFFFFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule